// File: doc/BRIEF.md
# DMA Cycle-Steal Bus Sequencer

This block decides, for one DMA channel, when the engine takes the system bus from the CPU and when it hands it back. Software arms it with a unit count, a unit size and a bus policy. From then on it follows an active-low, level-sensed transfer request. For each unit it raises a bus request, waits for the arbiter's grant and runs a read phase and then a write phase against memory (dual-address operation). It counts the unit down and then either keeps the bus or releases it, depending on the policy.

Two bus policies are available. Burst keeps the bus and moves units back to back while the request stays low. Cycle-steal gives the bus back after every unit, and it has three variants. The normal variant re-requests the bus at once. The two intermittent variants hold the bus request low for 16 or 64 clocks before asking again, which limits how much of the bus the DMA occupies. When the count reaches zero, a one-clock end flag is raised and the sequencer goes idle.

Each memory beat uses a strobe/done handshake that behaves like valid/ready. A read or write strobe rises and stays high, with `beat_sz` stable, until `mem_done` is sampled high on a clock edge. The beat completes on that edge. Holding `mem_done` low stalls the sequencer for any number of cycles without loss.

Top module: `dma_steal_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_req`, `rd_stb`, `wr_stb` and `xfer_end` are all low.
- R2: A `go` pulse in idle latches `burst_sel`, `steal_mode`, `unit_sz` and `xfer_cnt`. A `go` with `xfer_cnt` equal to 0 is ignored, so no bus request follows even when the request input is low.
- R3: Once armed, the bus is requested only while `req_n` is low. No `bus_req` is raised while `req_n` stays high.
- R4: The strobes stay low until `bus_gnt` has been returned for the current `bus_req`. A strobe is only ever high while both `bus_req` and `bus_gnt` are high.
- R5: Every unit is a read phase followed by a write phase, and both are never active together. Each strobe stays high until `mem_done` is sampled high.
- R6: `unit_sz` encodes 0 = byte, 1 = word, 2 = longword, 3 = 16-byte block. Byte, word and longword units take one read beat and one write beat, with `beat_sz` equal to `unit_sz`. A block unit takes four read beats and then four write beats, all with `beat_sz` = 2, within one bus tenure.
- R7: With `burst_sel` = 0 and `steal_mode` = 0 (normal), `bus_req` drops after every unit. If the request is still low, `bus_req` is raised again after exactly one low cycle.
- R8: With `steal_mode` = 1 or 2 (intermittent 16 or 64), `bus_req` stays low for exactly 16 or 64 cycles after each unit. A request that is seen low at any point in that wait is held and served when the wait ends, even if it has gone high again by then.
- R9: With `burst_sel` = 1, the bus is kept across units while `req_n` is low. If `req_n` is high when a unit ends, the bus is released and requested again once `req_n` goes low.
- R10: In burst mode, `steal_mode` has no effect: there is no inter-unit gap.
- R11: One cycle after the write phase of the last unit completes, `xfer_end` is high for exactly one cycle with `bus_req` low. The sequencer then idles with `bus_req` low.
- R12: Changing the mode inputs after `go` has no effect on a run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | One-cycle arm pulse; latches the settings below |
| xfer_cnt | input | CNT_W | Number of units to move |
| burst_sel | input | 1 | 1 = burst, 0 = cycle-steal |
| steal_mode | input | 2 | 0 normal, 1 intermittent-16, 2 intermittent-64 |
| unit_sz | input | 2 | 0 byte, 1 word, 2 longword, 3 16-byte block |
| req_n | input | 1 | Active-low level transfer request |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_req | output | 1 | Bus request to the arbiter |
| rd_stb | output | 1 | Read beat strobe, held until done |
| wr_stb | output | 1 | Write beat strobe, held until done |
| beat_sz | output | 2 | Width of the current beat (same encoding as unit_sz) |
| mem_done | input | 1 | Memory completes the current beat |
| xfer_end | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The sequencer is run under each policy with the request held low throughout, and the low time of `bus_req` between tenures is measured. A gap of 1, 16 or 64 cycles, or no gap at all, identifies normal cycle-steal, the two intermittent variants and burst respectively. Block-sized units are compared with single-beat units by counting read and write beats per tenure. The request is also pulsed high and low around unit boundaries, which shows whether burst releases the bus on a high request and whether a brief request during an intermittent wait is latched. A zero count, a request held high after arming, and mode changes after `go` check that the block ignores what it should.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_LONG  = 2'd2,
    SZ_BLK16 = 2'd3
  } unit_sz_e;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_GAP16  = 2'd1,
    ST_GAP64  = 2'd2,
    ST_RSVD   = 2'd3
  } steal_e;

  typedef struct packed {
    logic     burst;
    steal_e   steal;
    unit_sz_e size;
  } seq_cfg_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARMED,
    S_REQ,
    S_RD,
    S_WR,
    S_GAP,
    S_END
  } seq_state_e;

  localparam int BLK_BEATS = 4;

endpackage

// File: rtl/dma_gap_timer.sv
module dma_gap_timer #(
  parameter int GAP_SHORT = 16,
  parameter int GAP_LONG  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_sel,
  output logic expired
);
  localparam int TW = $clog2(GAP_LONG + 1);
  localparam logic [TW-1:0] LOAD_S = TW'(GAP_SHORT - 1);
  localparam logic [TW-1:0] LOAD_L = TW'(GAP_LONG - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start)         cnt_q <= long_sel ? LOAD_L : LOAD_S;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dma_unit_counter.sv
module dma_unit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             is_last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign is_last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/dma_tenure_fsm.sv
module dma_tenure_fsm
  import dma_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     go,
  input  logic     cnt_nonzero,
  input  seq_cfg_t cfg_in,
  input  logic     req_n,
  input  logic     bus_gnt,
  input  logic     mem_done,
  input  logic     cnt_last,
  input  logic     gap_expired,
  output logic     cnt_load,
  output logic     unit_done,
  output logic     gap_start,
  output logic     gap_long,
  output logic     bus_req,
  output logic     rd_stb,
  output logic     wr_stb,
  output logic [1:0] beat_sz,
  output logic     xfer_end
);
  localparam int BW = $clog2(BLK_BEATS);

  seq_state_e state_q, state_d;
  seq_cfg_t   cfg_q;
  logic [BW-1:0] beat_q;
  logic [BW-1:0] beat_max;
  logic          last_beat;
  logic          pend_q;
  logic          intermittent;

  assign beat_max     = (cfg_q.size == SZ_BLK16) ? BW'(BLK_BEATS - 1) : '0;
  assign last_beat    = (beat_q == beat_max);
  assign intermittent = !cfg_q.burst &&
                        (cfg_q.steal == ST_GAP16 || cfg_q.steal == ST_GAP64);

  assign cnt_load  = (state_q == S_IDLE) && go && cnt_nonzero;
  assign unit_done = (state_q == S_WR) && mem_done && last_beat;
  assign gap_start = unit_done && !cnt_last && intermittent;
  assign gap_long  = (cfg_q.steal == ST_GAP64);

  assign bus_req  = (state_q == S_REQ) || (state_q == S_RD) || (state_q == S_WR);
  assign rd_stb   = (state_q == S_RD);
  assign wr_stb   = (state_q == S_WR);
  assign xfer_end = (state_q == S_END);
  assign beat_sz  = (cfg_q.size == SZ_BLK16) ? 2'(SZ_LONG) : 2'(cfg_q.size);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (cnt_load) state_d = S_ARMED;
      S_ARMED: if (!req_n) state_d = S_REQ;
      S_REQ:   if (bus_gnt) state_d = S_RD;
      S_RD:    if (mem_done && last_beat) state_d = S_WR;
      S_WR: begin
        if (unit_done) begin
          if (cnt_last)          state_d = S_END;
          else if (cfg_q.burst)  state_d = req_n ? S_ARMED : S_RD;
          else if (intermittent) state_d = S_GAP;
          else                   state_d = S_ARMED;
        end
      end
      S_GAP:   if (gap_expired) state_d = (pend_q || !req_n) ? S_REQ : S_ARMED;
      S_END:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cfg_q   <= '{burst: 1'b0, steal: ST_NORMAL, size: SZ_BYTE};
      beat_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_load) cfg_q <= cfg_in;
      if ((state_q == S_RD || state_q == S_WR) && mem_done)
        beat_q <= last_beat ? '0 : beat_q + 1'b1;
      if (gap_start)
        pend_q <= 1'b0;
      else if (state_q == S_GAP && !req_n)
        pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_steal_seq.sv
module dma_steal_seq
  import dma_seq_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int GAP_SHORT = 16,
  parameter int GAP_LONG  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] xfer_cnt,
  input  logic             burst_sel,
  input  logic [1:0]       steal_mode,
  input  logic [1:0]       unit_sz,
  input  logic             req_n,
  input  logic             bus_gnt,
  output logic             bus_req,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic [1:0]       beat_sz,
  input  logic             mem_done,
  output logic             xfer_end
);
  seq_cfg_t cfg_in;
  logic cnt_load, unit_done, cnt_last;
  logic gap_start, gap_long, gap_expired;

  assign cfg_in = '{burst: burst_sel,
                    steal: steal_e'(steal_mode),
                    size:  unit_sz_e'(unit_sz)};

  dma_tenure_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (go),
    .cnt_nonzero (xfer_cnt != '0),
    .cfg_in      (cfg_in),
    .req_n       (req_n),
    .bus_gnt     (bus_gnt),
    .mem_done    (mem_done),
    .cnt_last    (cnt_last),
    .gap_expired (gap_expired),
    .cnt_load    (cnt_load),
    .unit_done   (unit_done),
    .gap_start   (gap_start),
    .gap_long    (gap_long),
    .bus_req     (bus_req),
    .rd_stb      (rd_stb),
    .wr_stb      (wr_stb),
    .beat_sz     (beat_sz),
    .xfer_end    (xfer_end)
  );

  dma_unit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (xfer_cnt),
    .dec      (unit_done),
    .is_last  (cnt_last)
  );

  dma_gap_timer #(.GAP_SHORT(GAP_SHORT), .GAP_LONG(GAP_LONG)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (gap_start),
    .long_sel (gap_long),
    .expired  (gap_expired)
  );
endmodule

// File: rtl/dma_steal_seq_chk.sv
module dma_steal_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic       rd_stb,
  input logic       wr_stb,
  input logic [1:0] beat_sz,
  input logic       mem_done,
  input logic       xfer_end
);
  // R5
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));

  // R4
  strobe_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> (bus_req && bus_gnt));

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !mem_done) |=> rd_stb);

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !mem_done) |=> wr_stb);

  // R5
  wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_stb) |-> $past(rd_stb && mem_done));

  // R6
  beat_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> (beat_sz != 2'd3));

  // R11
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> !xfer_end);

  // R11
  end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |-> (!bus_req && !rd_stb && !wr_stb));
endmodule

bind dma_steal_seq dma_steal_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_req  (bus_req),
  .bus_gnt  (bus_gnt),
  .rd_stb   (rd_stb),
  .wr_stb   (wr_stb),
  .beat_sz  (beat_sz),
  .mem_done (mem_done),
  .xfer_end (xfer_end)
);

// File: tb/tb_dma_steal_seq.sv
`timescale 1ns/1ps
module tb_dma_steal_seq;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic [CNT_W-1:0] xfer_cnt = '0;
  logic burst_sel = 1'b0;
  logic [1:0] steal_mode = 2'd0;
  logic [1:0] unit_sz = 2'd0;
  logic req_n = 1'b1;
  logic bus_gnt = 1'b0;
  logic bus_req, rd_stb, wr_stb, xfer_end;
  logic [1:0] beat_sz;
  logic mem_done = 1'b0;

  always #2.5 clk = ~clk;

  dma_steal_seq #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .go(go), .xfer_cnt(xfer_cnt),
    .burst_sel(burst_sel), .steal_mode(steal_mode), .unit_sz(unit_sz),
    .req_n(req_n), .bus_gnt(bus_gnt), .bus_req(bus_req),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .beat_sz(beat_sz),
    .mem_done(mem_done), .xfer_end(xfer_end)
  );

  // arbiter and memory models: one-cycle grant lag, done one cycle after strobe
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_gnt  <= 1'b0;
      mem_done <= 1'b0;
    end else begin
      bus_gnt  <= bus_req;
      mem_done <= (rd_stb || wr_stb) && !mem_done;
    end
  end

  int n_chk = 0, n_fail = 0;
  int rises, rd_beats, wr_beats, end_cnt, end_long, low_run;
  int gap_min, gap_max, sz_err, nogrant;
  int exp_sz;
  logic prev_req, prev_end;

  task automatic clear_stats(input int sz);
    rises = 0; rd_beats = 0; wr_beats = 0; end_cnt = 0; end_long = 0;
    low_run = 0; gap_min = 99999; gap_max = 0; sz_err = 0; nogrant = 0;
    exp_sz = sz; prev_req = 1'b0; prev_end = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_req && !prev_req) begin
        if (rises > 0) begin
          if (low_run < gap_min) gap_min = low_run;
          if (low_run > gap_max) gap_max = low_run;
        end
        rises++;
      end
      if (!bus_req) low_run++; else low_run = 0;
      if (rd_stb && mem_done) rd_beats++;
      if (wr_stb && mem_done) wr_beats++;
      if ((rd_stb || wr_stb) && int'(beat_sz) != exp_sz) sz_err++;
      if ((rd_stb || wr_stb) && !bus_gnt) nogrant++;
      if (xfer_end) end_cnt++;
      if (xfer_end && prev_end) end_long++;
      prev_req = bus_req;
      prev_end = xfer_end;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic start_run(input int cnt, input bit bst, input int mode, input int sz, input int esz);
    @(posedge clk); #1;
    clear_stats(esz);
    xfer_cnt = CNT_W'(cnt); burst_sel = bst;
    steal_mode = 2'(mode); unit_sz = 2'(sz); go = 1'b1;
    @(posedge clk); #1;
    go = 1'b0;
  endtask

  task automatic wait_end(input string tag);
    int t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!xfer_end && t < 5000);
    chk(t < 5000, tag, t, 5000);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic wait_wr_done();
    do @(negedge clk); while (!(wr_stb && mem_done));
  endtask

  task automatic end_checks(input string tag);
    chk_eq({tag, " R11 end pulses"}, end_cnt, 1);
    chk_eq({tag, " R11 end width"}, end_long, 0);
    chk_eq({tag, " R11 bus idle"}, int'(bus_req), 0);
    chk_eq({tag, " R6 beat_sz"}, sz_err, 0);
    chk_eq({tag, " R4 strobe w/o grant"}, nogrant, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk_eq("R1 bus_req in reset", int'(bus_req), 0);
    chk_eq("R1 strobes in reset", int'(rd_stb | wr_stb), 0);
    chk_eq("R1 xfer_end in reset", int'(xfer_end), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 outputs after reset", int'(bus_req | rd_stb | wr_stb | xfer_end), 0);
  endtask

  task automatic t_zero_count();
    req_n = 1'b0;
    start_run(0, 1'b0, 0, 0, 0);
    repeat (20) @(posedge clk);
    #1;
    chk_eq("R2 zero count ignored", rises, 0);
    req_n = 1'b1;
  endtask

  task automatic t_normal_level();
    req_n = 1'b1;
    start_run(2, 1'b0, 0, 0, 0);
    repeat (20) @(posedge clk);
    #1;
    chk_eq("R3 no request while req_n high", rises, 0);
    req_n = 1'b0;
    wait_end("R11 normal end");
    chk_eq("R5 normal read beats", rd_beats, 2);
    chk_eq("R5 normal write beats", wr_beats, 2);
    chk_eq("R7 normal tenures", rises, 2);
    chk_eq("R7 normal gap", gap_max, 1);
    end_checks("normal");
  endtask

  task automatic t_block();
    req_n = 1'b0;
    start_run(2, 1'b0, 0, 3, 2);
    wait_end("R11 block end");
    chk_eq("R6 block read beats", rd_beats, 8);
    chk_eq("R6 block write beats", wr_beats, 8);
    chk_eq("R6 block tenures", rises, 2);
    end_checks("block");
  endtask

  task automatic t_gap(input int mode, input int exp_gap);
    req_n = 1'b0;
    start_run(3, 1'b0, mode, 1, 1);
    wait_end("R11 gap end");
    chk_eq("R8 gap tenures", rises, 3);
    chk_eq("R8 gap min", gap_min, exp_gap);
    chk_eq("R8 gap max", gap_max, exp_gap);
    end_checks("gap");
  endtask

  task automatic t_burst_hold();
    req_n = 1'b0;
    start_run(3, 1'b1, 2, 2, 2);
    wait_end("R11 burst end");
    chk_eq("R9 burst single tenure", rises, 1);
    chk_eq("R10 burst ignores gap setting", wr_beats, 3);
    end_checks("burst");
  endtask

  task automatic t_burst_pause();
    req_n = 1'b0;
    start_run(3, 1'b1, 0, 2, 2);
    wait_wr_done();
    req_n = 1'b1;
    repeat (10) @(posedge clk);
    #1;
    chk_eq("R9 burst released on high request", int'(bus_req), 0);
    req_n = 1'b0;
    wait_end("R11 burst pause end");
    chk_eq("R9 burst pause tenures", rises, 2);
    chk_eq("R9 burst pause units", wr_beats, 3);
    end_checks("burst pause");
  endtask

  task automatic t_pending();
    req_n = 1'b0;
    start_run(2, 1'b0, 1, 0, 0);
    wait_wr_done();
    req_n = 1'b1;
    repeat (5) @(negedge clk);
    req_n = 1'b0;
    repeat (2) @(negedge clk);
    req_n = 1'b1;
    wait_end("R11 pending end");
    chk_eq("R8 pending request served", rises, 2);
    chk_eq("R8 pending gap length", gap_max, 16);
    end_checks("pending");
  endtask

  task automatic t_cfg_sample();
    req_n = 1'b0;
    start_run(2, 1'b0, 0, 0, 0);
    steal_mode = 2'd2; burst_sel = 1'b1; unit_sz = 2'd3;
    wait_end("R11 cfg end");
    chk_eq("R12 settings latched tenures", rises, 2);
    chk_eq("R12 settings latched gap", gap_max, 1);
    chk_eq("R12 settings latched beats", rd_beats, 2);
    end_checks("cfg");
  endtask

  initial begin
    clear_stats(0);
    t_reset();
    t_zero_count();
    t_normal_level();
    t_block();
    t_gap(1, 16);
    t_gap(2, 64);
    t_burst_hold();
    t_burst_pause();
    t_pending();
    t_cfg_sample();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule